// File: doc/BRIEF.md
# SPI flash read-command responder

This block is the target side of a serial flash memory's basic read command. It oversamples chip-select, serial clock and serial input with its own system clock. An 8-bit command is shifted in and recognised, a 24-bit start address follows, and the block then streams bytes from an internal byte array on the serial output. Streaming goes on until chip-select is released. The read pointer advances after every byte and wraps from the top of the array back to zero.

The serial output is presented as a data bit plus an output-enable, which the pad ring turns into a tri-state driver. The enable is low while the command and address are received, and it is low for any command other than a read. Both idle-low and idle-high serial clock polarities work without configuration. A separate synchronous write port fills the byte array. It is meant for preload only.

The system clock must give at least four clock periods per serial clock half-period. Chip-select must stay high for at least four system clock periods between two transactions.

Top module: `spi_rd_target`

## Requirements
- R1: A transaction starts when chip-select falls. The first 8 serial-input bits, sampled on rising serial clock edges with the MSB first, form the command. The value 0x03 selects a read.
- R2: After a read command, the next 24 bits sampled on rising edges form the start address, MSB first. Only the low MEM_AW bits select the byte, so higher address bits alias.
- R3: The output enable stays low throughout serial clocks 0 to 31, which carry the command and address.
- R4: From clock 32 on, bytes are output MSB first, back to back. They start at the received address and the address rises by one per byte. Each bit changes after a falling serial clock edge and is valid, with the enable high, at the following rising edge.
- R5: After the byte at address 2^MEM_AW-1, the next byte comes from address 0.
- R6: A rising chip-select drops the output enable at once, at any point in the stream. It returns the block to the command phase, so the next transaction works normally.
- R7: Any command other than 0x03 keeps the output enable low for the rest of the transaction, however many clocks follow.
- R8: Reads work both with the serial clock idle low (mode 0) and idle high (mode 3) when chip-select falls.
- R9: A write on the preload port with pl_we_i high stores pl_data_i at pl_addr_i on the rising system clock edge. Later reads return that value.
- R10: While rst_ni is low, and after it rises, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip-select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data out driver |
| pl_we_i | input | 1 | Preload write strobe |
| pl_addr_i | input | MEM_AW | Preload byte address |
| pl_data_i | input | 8 | Preload byte value |

## Verification
The bench reads across the top of the array, with a start address whose upper bits are set. A pointer that fails to wrap, or that decodes upper bits, returns the wrong byte there. It releases chip-select partway through a byte and then starts a new read. A design that keeps its bit count or its enable across the release would misalign the next stream or keep driving the line. It sends commands near 0x03 and pads them with many clocks, which catches a decoder that compares too few bits or falls into data mode anyway. It repeats reads in mode 3, where an extra falling edge before clock 0 would shift a design that counts falling edges.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = 24;
  localparam logic [CMD_W-1:0] CMD_READ = 8'h03;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rd_state_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int unsigned      WIDTH   = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
  import spi_rd_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sck_s_i,
  input  logic              si_s_i,
  input  logic [7:0]        rd_data_i,
  output logic [MEM_AW-1:0] rd_addr_o,
  output logic              so_o,
  output logic              oe_o,
  output rd_state_e         state_o,
  output logic              byte_ld_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_W);

  rd_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] sh_q;
  logic [ADDR_W-1:0] sh_nxt;
  logic [MEM_AW-1:0] addr_q;
  logic [7:0]        tx_q;
  logic [2:0]        bit_q;
  logic              oe_q;
  logic              sck_q;
  logic              sck_rise;
  logic              sck_fall;
  logic              byte_ld;

  assign sck_rise = sck_s_i & ~sck_q;
  assign sck_fall = ~sck_s_i & sck_q;
  assign sh_nxt   = {sh_q[ADDR_W-2:0], si_s_i};
  assign byte_ld  = !cs_n_s_i && (state_q == ST_DATA) && sck_fall && (bit_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else sck_q <= sck_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (cs_n_s_i) begin
      // deselected: park in command phase
      state_q <= ST_CMD;
      cnt_q   <= '0;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (sck_rise) begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CMD_W-1)) begin
            cnt_q   <= '0;
            state_q <= (sh_nxt[CMD_W-1:0] == CMD_READ) ? ST_ADDR : ST_SKIP;
          end
        end
        ST_ADDR: if (sck_rise) begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_W-1)) begin
            cnt_q   <= '0;
            addr_q  <= sh_nxt[MEM_AW-1:0];
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (sck_fall) begin
          oe_q  <= 1'b1;
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd0) begin
            tx_q   <= rd_data_i;
            addr_q <= addr_q + 1'b1;  // prefetch next byte, wraps at top
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
        default: ;  // ST_SKIP: hold until deselect
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign so_o      = tx_q[7];
  assign oe_o      = oe_q;
  assign state_o   = state_q;
  assign byte_ld_o = byte_ld;
endmodule

// File: rtl/spi_rd_target.sv
module spi_rd_target
  import spi_rd_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              pl_we_i,
  input  logic [MEM_AW-1:0] pl_addr_i,
  input  logic [7:0]        pl_data_i
);
  logic [2:0]        pins_s;
  logic [7:0]        rd_data;
  logic [MEM_AW-1:0] eng_rd_addr;
  logic              eng_oe;
  rd_state_e         eng_state;
  logic              eng_byte_ld;

  spi_rd_sync #(
    .WIDTH  (3),
    .STAGES (2),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_n_i, sck_i, si_i}),
    .q_o   (pins_s)
  );

  spi_rd_mem #(
    .AW(MEM_AW)
  ) u_mem (
    .clk_i  (clk_i),
    .we_i   (pl_we_i),
    .waddr_i(pl_addr_i),
    .wdata_i(pl_data_i),
    .raddr_i(eng_rd_addr),
    .rdata_o(rd_data)
  );

  spi_rd_engine #(
    .MEM_AW(MEM_AW)
  ) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (pins_s[2]),
    .sck_s_i  (pins_s[1]),
    .si_s_i   (pins_s[0]),
    .rd_data_i(rd_data),
    .rd_addr_o(eng_rd_addr),
    .so_o     (so_o),
    .oe_o     (eng_oe),
    .state_o  (eng_state),
    .byte_ld_o(eng_byte_ld)
  );

  // raw chip-select gates the driver so release takes effect without sync delay
  assign so_oe_o = eng_oe & ~cs_n_i;
endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker
  import spi_rd_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic              so_oe_o,
  input rd_state_e         state_i,
  input logic [MEM_AW-1:0] rd_addr_i,
  input logic              byte_ld_i
);
  assert_cs_release_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !so_oe_o);

  assert_hdr_hiz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CMD || state_i == ST_ADDR) |-> !so_oe_o);

  assert_bad_cmd_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SKIP) |-> !so_oe_o);

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ld_i |=> (rd_addr_i == MEM_AW'($past(rd_addr_i) + 1'b1)));

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DATA && !byte_ld_i) |=> $stable(rd_addr_i));

  assert_reset_hiz_R10: assert property (@(posedge clk_i)
    !rst_ni |-> !so_oe_o);
endmodule

bind spi_rd_target spi_rd_checker #(.MEM_AW(MEM_AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_n_i   (cs_n_i),
  .so_oe_o  (so_oe_o),
  .state_i  (eng_state),
  .rd_addr_i(eng_rd_addr),
  .byte_ld_i(eng_byte_ld)
);

// File: tb/spi_rd_target_bench.sv
module spi_rd_target_bench;
  localparam int AW   = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sck, si, pl_we;
  logic [AW-1:0] pl_addr;
  logic [7:0] pl_data;
  logic so_d, so_oe;

  logic [7:0] model [1 << AW];
  int checks = 0;
  int errors = 0;
  bit bad_op = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  spi_rd_target #(.MEM_AW(AW)) u_spi_rd_target (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so_d), .so_oe_o(so_oe),
    .pl_we_i(pl_we), .pl_addr_i(pl_addr), .pl_data_i(pl_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: assembles output bytes and compares against the scoreboard
  int mon_edge = 0;
  int mon_bits = 0;
  logic [7:0] mon_sh = '0;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      mon_edge = 0;
      mon_bits = 0;
    end else begin
      if (bad_op) check(so_oe == 1'b0, "R7 enable after bad command", int'(so_oe), 0);
      else if (mon_edge < 32) check(so_oe == 1'b0, "R3 enable in header", int'(so_oe), 0);
      else begin
        check(so_oe == 1'b1, "R4 enable in data", int'(so_oe), 1);
        mon_sh = {mon_sh[6:0], so_d};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          if (exp_q.size() != 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(mon_sh == e, t, int'(mon_sh), int'(e));
          end
        end
      end
      mon_edge++;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sck = 1'b0;
    si  = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic preload(int a, logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = AW'(a); pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    model[a] = d;
  endtask

  // driver: pushes expected bytes, then clocks the transaction
  task automatic xfer(bit m3, logic [7:0] op, logic [23:0] addr, int nbytes, int extra, string tag);
    bad_op = (op != 8'h03);
    sck = m3;
    wait_clk(4);
    if (!bad_op) begin
      for (int i = 0; i < nbytes; i++) begin
        exp_q.push_back(model[(int'(addr[AW-1:0]) + i) % (1 << AW)]);
        tag_q.push_back(tag);
      end
    end
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 7; i >= 0; i--) send_bit(op[i]);
    for (int i = 23; i >= 0; i--) send_bit(addr[i]);
    for (int i = 0; i < nbytes * 8 + extra; i++) send_bit(1'b0);
    if (extra > 0) check(so_oe == 1'b1, "R6 enable before release", int'(so_oe), 1);
    if (!m3) begin
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    #1;
    check(so_oe == 1'b0, "R6 enable after release", int'(so_oe), 0);
    wait_clk(6);
    bad_op = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    wait_clk(5);
    check(so_oe == 1'b0, "R10 enable in reset", int'(so_oe), 0);
    rst_n = 1'b1;
    wait_clk(3);
    check(so_oe == 1'b0, "R10 enable after reset", int'(so_oe), 0);

    for (int a = 0; a < (1 << AW); a++) preload(a, 8'((a * 37 + 11) ^ (a >> 2)));

    xfer(1'b0, 8'h03, 24'h000010, 6, 0, "R1 R4 mode0 stream");
    xfer(1'b1, 8'h03, 24'h000123, 5, 0, "R8 mode3 stream");
    xfer(1'b0, 8'h03, 24'h0003FD, 5, 0, "R5 wrap mode0");
    xfer(1'b1, 8'h03, 24'h7F03FE, 4, 0, "R2 R5 aliased wrap mode3");
    xfer(1'b0, 8'h0B, 24'h000010, 3, 0, "R7");
    xfer(1'b1, 8'h02, 24'h000020, 2, 0, "R7");
    xfer(1'b0, 8'h83, 24'h000030, 2, 0, "R7");
    xfer(1'b0, 8'h03, 24'h000200, 2, 4, "R6 aborted stream");
    xfer(1'b1, 8'h03, 24'h000040, 3, 0, "R6 stream after abort");
    preload(5, 8'hA5);
    preload(6, 8'h3C);
    xfer(1'b0, 8'h03, 24'h000004, 4, 0, "R9 preload readback");
    xfer(1'b1, 8'h03, 24'h0003FF, 3, 0, "R5 top byte mode3");

    check(exp_q.size() == 0, "R4 bytes outstanding", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule